// File: doc/BRIEF.md
# Seconds Counter Timer

This block keeps a running count of whole seconds. An external 32.768 kHz reference clock feeds it. The block samples that reference in the system clock domain and finds its rising edges. It divides the edges by a fixed ratio, 32768 by default, to make a once-per-second step for a wide up-counter. The counter only counts upward. After the all-ones value it wraps to zero and keeps going.

Software controls the block through these inputs:
- an enable level;
- a shared write-data bus with two write strobes, one for the load value and one for the match value;
- an interrupt mask level;
- a DMA-enable level;
- a clear strobe that acts as a write-one-to-clear.

The block has two count outputs that always carry the same value. When the count steps onto the match value, a status bit latches. This never stops or restarts the count. That status bit, after masking, drives the interrupt. If DMA is enabled, the same event also gives a one-cycle DMA trigger.

Top module: `seconds_timer`

## Requirements
- R1: While reset is asserted and right after it, the count is 0, the raw and masked status are 0, and the interrupt and DMA trigger are 0.
- R2: On the first enable after reset, the count becomes 1, provided no load value was written before it. Later enables do not reseed the count.
- R3: While enabled, the count rises by exactly one for every DIV_RATIO rising edges of the reference input. Fewer edges leave the count unchanged.
- R4: A load strobe puts the write-data value into the count on the next clock, whether the block is enabled or not. Counting continues upward from that value.
- R5: When an increment makes the count equal the match value, the raw status is set, and counting continues with no reload.
- R6: Counting is up only. The count wraps from all ones to 0 on the next increment.
- R7: The masked status and the interrupt output are high only when the raw status is high and the mask input is 1.
- R8: A clear strobe drops the raw status, and with it the masked status and the interrupt.
- R9: Each match gives exactly one single-cycle high on the DMA trigger when the DMA enable is 1, and no pulse when it is 0.
- R10: With enable low, the count holds whatever the reference does. The divider phase restarts from zero, so after re-enable a full DIV_RATIO edges are needed for the next increment.
- R11: The count output and the free-running value output are equal at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, far faster than the reference |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | 32.768 kHz reference, asynchronous to clk_i |
| run_en_i | input | 1 | Counting enable |
| wr_data_i | input | CNT_W | Write data for load and match writes |
| load_wr_i | input | 1 | Strobe: write wr_data_i into the count |
| match_wr_i | input | 1 | Strobe: write wr_data_i into the match register |
| irq_mask_i | input | 1 | 1 lets the status reach the interrupt |
| dma_en_i | input | 1 | 1 lets a match produce a DMA trigger |
| clr_i | input | 1 | Write-one-to-clear strobe for the match status |
| count_o | output | CNT_W | Current count |
| value_o | output | CNT_W | Free-running value, equal to count_o |
| raw_stat_o | output | 1 | Raw match status |
| masked_stat_o | output | 1 | Masked match status |
| irq_o | output | 1 | Interrupt request |
| dma_trig_o | output | 1 | Single-cycle DMA trigger |

## Verification
The bench builds the block with CNT_W = 8 and DIV_RATIO = 4. With these values, one second takes only four reference edges, and the all-ones wrap is 256 steps away. A sweep over load values every five counts, with a match placed two steps ahead, then reaches every region of the count space. The sweep alternates the mask and DMA-enable settings. A full 256-step lap checks the wrap and the single match per lap. Separate checks cover partial-second edge counts, pausing, and first-enable seeding.

// File: rtl/seconds_timer_pkg.sv
package seconds_timer_pkg;

  // Cause of a count register update, in priority order
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_INIT = 2'd2,
    UPD_STEP = 2'd3
  } upd_e;

  localparam int unsigned REF_DIV_DEFAULT = 32768;
  localparam int unsigned CNT_W_DEFAULT   = 32;
  localparam int unsigned SYNC_DEFAULT    = 2;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int unsigned SYNC_STAGES = seconds_timer_pkg::SYNC_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q, last_d;

  // Shift chain toward the MSB; the MSB is the settled copy
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], ref_i};
    end else begin : g_single
      always_comb sync_d = ref_i;
    end
  endgenerate

  always_comb last_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R3: a detected edge never lasts two cycles
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned DIV_RATIO = seconds_timer_pkg::REF_DIV_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rise_i,
  output logic tick_o
);

  localparam int unsigned DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_RATIO - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             tick_q, tick_d;

  always_comb begin
    div_d  = div_q;
    tick_d = 1'b0;
    if (!run_i) begin
      div_d = '0;
    end else if (rise_i) begin
      if (div_q == LAST) begin
        div_d  = '0;
        tick_d = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R3: one-second step is a single-cycle strobe
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R10: no step is produced while paused
  tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o);

endmodule

// File: rtl/seconds_count_core.sv
module seconds_count_core
  import seconds_timer_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o
);

  localparam logic [CNT_W-1:0] SEED = CNT_W'(1);

  upd_e             upd;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seeded_q, seeded_d;
  logic             step_q, step_d;

  always_comb begin
    if (load_wr_i)                upd = UPD_LOAD;
    else if (run_i && !seeded_q)  upd = UPD_INIT;
    else if (run_i && tick_i)     upd = UPD_STEP;
    else                          upd = UPD_NONE;
  end

  always_comb begin
    cnt_d    = cnt_q;
    seeded_d = seeded_q;
    step_d   = 1'b0;
    unique case (upd)
      UPD_LOAD: begin
        cnt_d    = load_val_i;
        seeded_d = 1'b1;
      end
      UPD_INIT: begin
        cnt_d    = SEED;
        seeded_d = 1'b1;
      end
      UPD_STEP: begin
        cnt_d  = cnt_q + 1'b1;
        step_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      seeded_q <= 1'b0;
      step_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      seeded_q <= seeded_d;
      step_q   <= step_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign step_o = step_q;

  // R10: paused and not loaded means the count holds
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_wr_i) |=> $stable(cnt_q));

  // R4: a load lands on the next clock
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_i |=> (cnt_q == $past(load_val_i)));

  // R6: all ones steps to zero
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && seeded_q && !load_wr_i && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/match_status.sv
module match_status #(
  parameter int unsigned CNT_W = seconds_timer_pkg::CNT_W_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic             match_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             mask_i,
  input  logic             dma_en_i,
  input  logic             clr_i,
  output logic             raw_o,
  output logic             masked_o,
  output logic             dma_o
);

  logic [CNT_W-1:0] match_q, match_d;
  logic             raw_q, raw_d;
  logic             dma_q, dma_d;
  logic             hit;

  always_comb begin
    hit     = step_i && (cnt_i == match_q);
    match_d = match_wr_i ? wr_data_i : match_q;
    // a fresh match outranks a clear in the same cycle
    if (hit)        raw_d = 1'b1;
    else if (clr_i) raw_d = 1'b0;
    else            raw_d = raw_q;
    dma_d = hit && dma_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      match_q <= match_d;
      raw_q   <= raw_d;
      dma_q   <= dma_d;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
  assign dma_o    = dma_q;

  // R5
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (cnt_i == match_q)) |=> raw_q);

  // R8
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(raw_q) |-> $past(clr_i));

  // R9
  dma_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_q |=> !dma_q);

  // R9
  dma_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_q |-> ($past(dma_en_i) && raw_q));

endmodule

// File: rtl/seconds_timer.sv
module seconds_timer
  import seconds_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEFAULT,
  parameter int unsigned DIV_RATIO   = REF_DIV_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             run_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_wr_i,
  input  logic             match_wr_i,
  input  logic             irq_mask_i,
  input  logic             dma_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] value_o,
  output logic             raw_stat_o,
  output logic             masked_stat_o,
  output logic             irq_o,
  output logic             dma_trig_o
);

  logic             rise;
  logic             tick;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic             masked;

  ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .rise_o (rise)
  );

  tick_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_en_i),
    .rise_i (rise),
    .tick_o (tick)
  );

  seconds_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_en_i),
    .tick_i     (tick),
    .load_wr_i  (load_wr_i),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt),
    .step_o     (step)
  );

  match_status #(.CNT_W(CNT_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .step_i     (step),
    .match_wr_i (match_wr_i),
    .wr_data_i  (wr_data_i),
    .mask_i     (irq_mask_i),
    .dma_en_i   (dma_en_i),
    .clr_i      (clr_i),
    .raw_o      (raw_stat_o),
    .masked_o   (masked),
    .dma_o      (dma_trig_o)
  );

  assign count_o       = cnt;
  assign value_o       = cnt;
  assign masked_stat_o = masked;
  assign irq_o         = masked;

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_mask_i && raw_stat_o));

endmodule

// File: tb/sim_seconds_timer.sv
module sim_seconds_timer;

  localparam int unsigned W   = 8;
  localparam int unsigned DIV = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ref_in, run_en, load_wr, match_wr, mask, dma_en, clr;
  logic [W-1:0] wr_data;
  logic [W-1:0] count, value;
  logic         raw, masked, irq, dma;

  int checks = 0;
  int fails  = 0;
  int dma_seen = 0;
  int dma_wide = 0;
  logic dma_last = 1'b0;

  always #4 clk = ~clk;

  seconds_timer #(.CNT_W(W), .DIV_RATIO(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_in), .run_en_i(run_en),
    .wr_data_i(wr_data), .load_wr_i(load_wr), .match_wr_i(match_wr),
    .irq_mask_i(mask), .dma_en_i(dma_en), .clr_i(clr),
    .count_o(count), .value_o(value), .raw_stat_o(raw),
    .masked_stat_o(masked), .irq_o(irq), .dma_trig_o(dma)
  );

  always @(negedge clk) begin
    if (dma) dma_seen++;
    if (dma && dma_last) dma_wide++;
    dma_last = dma;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      ref_in = 1'b1; idle(3);
      ref_in = 1'b0; idle(3);
    end
    idle(10);
  endtask

  task automatic wr(input logic is_load, input logic [W-1:0] d);
    wr_data = d;
    if (is_load) load_wr = 1'b1; else match_wr = 1'b1;
    idle(1);
    load_wr = 1'b0; match_wr = 1'b0;
    idle(1);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; idle(1); clr = 1'b0; idle(1);
  endtask

  task automatic chk_status(input string tag, input logic exp_raw, input logic m);
    chk({tag, " raw"}, raw, exp_raw);
    chk({"R7 masked"}, masked, exp_raw & m);
    chk({"R7 irq"}, irq, exp_raw & m);
    chk("R11 count==value", value, count);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_in = 1'b0; run_en = 1'b0; load_wr = 1'b0;
    match_wr = 1'b0; mask = 1'b0; dma_en = 1'b0; clr = 1'b0; wr_data = '0;
    idle(5);
    // R1 during reset
    chk("R1 count in reset", count, 0);
    chk("R1 raw in reset", raw, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", dma, 0);
    chk("R1 masked", masked, 0);

    // R2 first enable seeds 1
    run_en = 1'b1; idle(4);
    chk("R2 seed", count, 1);
    // R3 partial second leaves count
    edges(DIV - 1);
    chk("R3 partial", count, 1);
    edges(1);
    chk("R3 full second", count, 2);
    // R10 pause holds, divider restarts
    edges(DIV - 1);
    run_en = 1'b0; idle(2);
    edges(2 * DIV);
    chk("R10 held", count, 2);
    run_en = 1'b1; idle(4);
    chk("R2 no reseed", count, 2);
    edges(1);
    chk("R10 phase restart", count, 2);
    edges(DIV - 1);
    chk("R10 resume", count, 3);

    // R4 load while paused
    run_en = 1'b0; idle(2);
    wr(1'b1, 8'h5A);
    chk("R4 load paused", count, 8'h5A);
    run_en = 1'b1; idle(2);
    edges(DIV);
    chk("R4 count from load", count, 8'h5B);

    // Sweep of load values with a match two steps ahead
    for (int l = 0; l < 256; l += 5) begin
      logic m, d;
      int base;
      m = l[0]; d = l[1];
      mask = m; dma_en = d;
      pulse_clr();
      chk_status("R8 cleared", 1'b0, m);
      wr(1'b0, W'(l + 2));
      wr(1'b1, W'(l));
      base = dma_seen;
      edges(3 * DIV);
      chk("R3/R6 sweep count", count, (l + 3) % 256);
      chk_status("R5 match", 1'b1, m);
      chk("R9 dma count", dma_seen - base, d ? 1 : 0);
    end

    // R6 full lap with exactly one match
    mask = 1'b1; dma_en = 1'b1;
    pulse_clr();
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h00);
    begin
      int base;
      base = dma_seen;
      edges(256 * DIV);
      chk("R6 lap returns", count, 0);
      chk("R9 one per lap", dma_seen - base, 1);
    end
    chk_status("R5 lap", 1'b1, 1'b1);

    // R6 explicit wrap
    pulse_clr();
    wr(1'b1, 8'hFE);
    edges(DIV);
    chk("R6 to ff", count, 8'hFF);
    edges(DIV);
    chk("R6 wrap zero", count, 8'h00);
    edges(DIV);
    chk("R6 past zero", count, 8'h01);
    chk("R8 no stray set", raw, 0);

    chk("R9 never wide", dma_wide, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule